// File: doc/BRIEF.md
# Framed Counting Stream Source

This block drives an AXI4-Stream master port with a run of incrementing count values. It is meant as a stimulus source in front of a DMA write channel. Software controls it through two plain inputs: a start bit and a length limit. Nothing is sent until software raises start. A rising edge of start launches one packet whose beats carry 0, 1, 2 … up to the limit value. The beat that carries the limit value is flagged with tlast. After that beat is accepted, the block falls silent until start rises again.

The downstream ready signal may be high long before software has set up the receiving side. For that reason the block never sends on ready alone. Only an explicit start edge opens a packet. The limit is captured at launch, so software may change it while a packet is in flight without disturbing that packet.

Top module: `axis_count_source`

## Requirements
- R1: While `rst_n` is low at a clock edge (synchronous, active low), the block returns to idle: after that edge `m_tvalid`, `m_tlast` and `m_tdata` are all 0.
- R2: In idle, with no rising edge on `start`, `m_tvalid` stays 0 whatever the level of `m_tready`.
- R3: If `start` is sampled high at a clock edge after being sampled low at the previous edge while the block is idle, `m_tvalid` is 1 after that edge and the first beat carries `m_tdata` = 0.
- R4: The count on `m_tdata` advances by exactly one only at edges where `m_tvalid` and `m_tready` are both 1. It does not change on any other edge during a packet.
- R5: While `m_tvalid` is 1 and `m_tready` is 0, `m_tvalid`, `m_tdata` and `m_tlast` hold their values into the next cycle.
- R6: A packet launched with limit L carries L+1 beats with values 0..L. `m_tlast` is 1 on the beat whose value equals L and on no other beat.
- R7: A limit of 0 gives a single-beat packet: value 0 with `m_tlast` = 1.
- R8: After the beat flagged with `m_tlast` is accepted, `m_tvalid` is 0 from the next cycle on. It stays 0 while `start` is held high. A new packet needs `start` to go low and then high again.
- R9: During a packet, edges on `start` and changes of `limit` have no effect. The packet ends at the limit captured at launch.
- R10: Every packet restarts its count from 0, whatever value the previous packet ended on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch request; a rising edge opens one packet |
| limit | input | LEN_W | Value carried by the last beat; the packet has limit+1 beats |
| m_tdata | output | DATA_W | Count value, zero-extended |
| m_tvalid | output | 1 | Beat valid |
| m_tready | input | 1 | Downstream ready |
| m_tlast | output | 1 | Final beat of the packet |

## Verification
The bench builds the block with DATA_W = 16 and LEN_W = 6. With LEN_W = 6 the largest limit, 63, fits in a short run, so a packet that spans the whole count range is reached and checked end to end. It also shows that the upper data bits stay at zero. Packets are driven under several ready patterns, from always ready to sparse, so that stalls fall on the first beat, on middle beats and on the last beat. Directed cases cover start held high across the end of a packet, start edges and limit changes in mid-packet, and reset in mid-packet.

// File: rtl/axis_count_source.sv
module axis_count_source #(
  parameter int DATA_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LEN_W-1:0]  limit,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);

  logic             start_q;
  logic             busy;
  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] lim_q;
  logic             launch;
  logic             fire;
  logic             at_end;

  assign launch = start & ~start_q;
  assign fire   = busy & m_tready;
  assign at_end = (cnt == lim_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      start_q <= 1'b0;
      busy    <= 1'b0;
      cnt     <= '0;
      lim_q   <= '0;
    end else begin
      start_q <= start;
      if (!busy) begin
        if (launch) begin
          busy  <= 1'b1;
          cnt   <= '0;
          lim_q <= limit;
        end
      end else if (fire) begin
        if (at_end) busy <= 1'b0;
        else        cnt  <= cnt + 1'b1;
      end
    end
  end

  assign m_tvalid = busy;
  assign m_tlast  = busy & at_end;

  always_comb begin
    m_tdata            = '0;
    m_tdata[LEN_W-1:0] = cnt;
  end

  AST_LAUNCH_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> (m_tdata == '0) && $past(start)); // R3
  AST_STEP_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && !m_tlast) |=> (m_tvalid && m_tdata == $past(m_tdata) + 1'b1)); // R4
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast))); // R5
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    m_tlast |-> m_tvalid); // R6
  AST_IDLE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && m_tready && m_tlast) |=> !m_tvalid); // R8

endmodule

// File: tb/sim_axis_count_source.sv
module sim_axis_count_source;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int LW = 6;

  // {limit[13:8], ready mask[7:0]}
  localparam logic [15:0] VEC [0:5] = '{
    16'h03FF, 16'h00FF, 16'h05A5, 16'h3FFF, 16'h0711, 16'h010F
  };

  logic clk = 0, rst_n = 0, start = 0, m_tready = 0;
  logic [LW-1:0] limit = '0;
  logic [DW-1:0] m_tdata;
  logic m_tvalid, m_tlast;
  int checks = 0, failures = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  axis_count_source #(.DATA_W(DW), .LEN_W(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .limit(limit),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input int lim);
    @(negedge clk); limit = LW'(lim); start = 1;
    @(negedge clk); start = 0;
    #1;
    chk(m_tvalid == 1, "R3 valid after start", int'(m_tvalid), 1);
    chk(m_tdata == 0, "R10 first value zero", int'(m_tdata), 0);
  endtask

  // entered just after a negedge following the launch edge
  task automatic drain(input int lim, input logic [7:0] mask, input string tag);
    int exp = 0;
    bit fin = 0;
    for (int i = 0; i < 2000 && !fin; i++) begin
      m_tready = mask[i % 8];
      #1;
      chk(m_tvalid == 1, {tag, " R4 valid held during packet"}, int'(m_tvalid), 1);
      chk(m_tdata == DW'(exp), {tag, " R6 value"}, int'(m_tdata), exp);
      chk(m_tlast == (exp == lim), {tag, " R6 tlast position"}, int'(m_tlast), int'(exp == lim));
      if (m_tready) begin
        if (exp == lim) fin = 1;
        else exp++;
      end
      @(negedge clk);
    end
    m_tready = 1;
    #1;
    chk(m_tvalid == 0, {tag, " R8 idle after last"}, int'(m_tvalid), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(m_tvalid == 0 && m_tlast == 0 && m_tdata == 0, "R1 reset state",
        int'(m_tvalid) + int'(m_tlast) + int'(m_tdata), 0);
    @(negedge clk); rst_n = 1; m_tready = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); #1;
      chk(m_tvalid == 0, "R2 ready without start", int'(m_tvalid), 0);
    end

    for (int v = 0; v < 6; v++) begin
      launch(int'(VEC[v][13:8]));
      drain(int'(VEC[v][13:8]), VEC[v][7:0], (VEC[v][13:8] == 0) ? "R7" : "R6");
    end

    // R8: start held high across the end of a packet
    @(negedge clk); limit = 2; start = 1;
    @(negedge clk);
    drain(2, 8'hFF, "R8 held");
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); #1;
      chk(m_tvalid == 0, "R8 no relaunch while start held", int'(m_tvalid), 0);
    end
    start = 0;
    launch(1);
    drain(1, 8'hFF, "R8 relaunch");

    // R9: start edges and limit change during a stalled packet
    m_tready = 0;
    launch(4);
    for (int i = 0; i < 6; i++) begin
      m_tready = 0; start = i[0]; limit = 1;
      @(negedge clk); #1;
      chk(m_tdata == 0 && m_tvalid == 1, "R9 stall unaffected by start", int'(m_tdata), 0);
    end
    start = 0;
    @(negedge clk);
    drain(4, 8'hFF, "R9");

    // R1: reset in mid-packet
    m_tready = 0;
    launch(5);
    m_tready = 1;
    @(negedge clk); @(negedge clk);
    rst_n = 0;
    @(negedge clk); #1;
    chk(m_tvalid == 0 && m_tlast == 0 && m_tdata == 0, "R1 reset mid-packet",
        int'(m_tvalid) + int'(m_tdata), 0);
    rst_n = 1;
    launch(3);
    drain(3, 8'h33, "R10 after reset");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule